// File: doc/BRIEF.md
# Background ECC Patrol Scrubber

This block patrols a memory array of 72-bit protected words while the memory is otherwise idle. Each word is 64 data bits and 8 SECDED check bits. At a programmable slow rate, it reads one word, recomputes the Hamming check and classifies the result. The result is clean, a single-bit error or an uncorrectable error. A single-bit error is written back as a fresh, fully valid codeword. A later upset in the same word then meets a clean word and cannot combine with the earlier one into a double error.

Every correction raises a one-cycle correctable-event pulse that carries the word address and the position of the flipped bit. An uncorrectable word is never rewritten. Instead it raises a one-cycle uncorrectable-event pulse that carries its address. The scrubber has a single memory request channel with a registered read response. A host-priority input makes the scrubber hold back any request. While that input is high the scrubber keeps its place, so no location is skipped.

Top module: `ecc_patrol_scrubber`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req`, `ce_pulse` and `ue_pulse` are 0.
- R2: When `scrub_interval` is 0, no new scrub read is issued, whatever the value of `scrub_en`.
- R3: Scrub reads visit the addresses in ascending order, from 0 up to DEPTH-1, and then return to 0.
- R4: The codeword layout is as follows. Bit 0 is the overall parity over all 72 bits, which is even when the word is good. Bits 1, 2, 4, 8, 16, 32 and 64 are the Hamming check bits. The 64 data bits fill the remaining positions 3..71 in ascending order, starting from data bit 0. A word that has one flipped data bit is written back to the same address as the correct codeword.
- R5: Each single-bit correction produces one `ce_pulse`. During that pulse, `ce_addr` holds the word address and `ce_pos` holds the codeword bit position that was flipped (0 to 71).
- R6: A word is uncorrectable when it has even overall parity and a nonzero syndrome, or odd parity and a syndrome above 71. Such a word gives one `ue_pulse` with its address on `ue_addr`, is not written, and the scrub continues with the next address.
- R7: While `host_busy` is high, `mem_req` stays low. A deferred scrub later goes to the same address, so no location is skipped.
- R8: A clean word, meaning zero syndrome and even overall parity, is never written back.
- R9: A single error in a check bit or in the overall parity bit is also corrected and written back as the full correct codeword.
- R10: When `scrub_en` is low, no new scrub read is issued.
- R11: Successive scrub read requests are at least `scrub_interval` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scrub_en | input | 1 | Allows new scrub reads to start |
| scrub_interval | input | IW | Minimum number of cycles between scrub reads; 0 pauses scrubbing |
| host_busy | input | 1 | Host has priority, so the scrubber defers its request |
| mem_req | output | 1 | Memory request; taken in the cycle it is high |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 72 | Codeword to write |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 72 | Read response codeword |
| ce_pulse | output | 1 | Correctable-event pulse |
| ce_addr | output | AW | Address of the last corrected word |
| ce_pos | output | 7 | Bit position that was corrected |
| ue_pulse | output | 1 | Uncorrectable-event pulse |
| ue_addr | output | AW | Address of the last uncorrectable word |

## Verification
The hardest case to reach is a scrub request held off by host priority at the moment the scrubber is ready to issue it. It is harder still when that deferred request is the write-back of a correction. The deferral must not lose the address and must not advance the walk. To reach it, the bench asserts `host_busy` at random on about a third of all cycles across full passes that contain injected single and double errors. It then holds `host_busy` high for a long stretch while scrubbing is enabled, and checks that the first read after release goes to the address that was due.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int DW = 64;
  localparam int CW = 72;
  localparam int PW = 7;

  typedef logic [CW-1:0] cword_t;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_CHK, S_WR} scrub_st_e;
  typedef enum logic [1:0] {V_CLEAN, V_SINGLE, V_DOUBLE} verdict_e;

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // XOR of the positions of all set bits 1..71
  function automatic logic [PW-1:0] hamming_syndrome(cword_t cw);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 1; i < CW; i++)
      if (cw[i]) s = s ^ PW'(i);
    return s;
  endfunction

  function automatic cword_t secded_encode(logic [DW-1:0] d);
    cword_t cw;
    logic [PW-1:0] s;
    int k;
    cw = '0;
    k = 0;
    for (int i = 1; i < CW; i++)
      if (!is_pow2(i)) begin
        cw[i] = d[k];
        k++;
      end
    s = hamming_syndrome(cw);
    for (int b = 0; b < PW; b++) cw[1 << b] = s[b];
    cw[0] = ^cw[CW-1:1];
    return cw;
  endfunction
endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          idle,
  input  logic [IW-1:0] interval,
  output logic          kick
);
  logic [IW-1:0] cnt;
  logic          armed;

  assign armed = en && (interval != '0);
  assign kick  = idle && armed && (cnt >= interval - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!idle || !armed || kick) cnt <= '0;
    else                              cnt <= cnt + IW'(1);
  end
endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (step) addr <= (addr == LAST) ? '0 : addr + AW'(1);
  end
endmodule

// File: rtl/secded_check.sv
module secded_check
  import scrub_pkg::*;
(
  input  cword_t            cw,
  output verdict_e          verdict,
  output logic [PW-1:0]     pos,
  output cword_t            fixed
);
  logic [PW-1:0] syn;
  logic          odd;

  always_comb begin
    syn     = hamming_syndrome(cw);
    odd     = ^cw;
    pos     = syn;
    fixed   = cw;
    verdict = V_DOUBLE;
    if (!odd && syn == '0) begin
      verdict = V_CLEAN;
    end else if (odd && int'(syn) < CW) begin
      verdict = V_SINGLE;
      fixed   = cw ^ (cword_t'(1) << syn);
    end
  end
endmodule

// File: rtl/ecc_patrol_scrubber.sv
module ecc_patrol_scrubber
  import scrub_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IW    = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scrub_en,
  input  logic [IW-1:0] scrub_interval,
  input  logic          host_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [CW-1:0] mem_rdata,
  output logic          ce_pulse,
  output logic [AW-1:0] ce_addr,
  output logic [PW-1:0] ce_pos,
  output logic          ue_pulse,
  output logic [AW-1:0] ue_addr
);
  scrub_st_e     state, state_nx;
  cword_t        rd_q, wr_q;
  logic [AW-1:0] addr;
  logic          kick;
  verdict_e      verdict;
  logic [PW-1:0] bad_pos;
  cword_t        fixed_cw;

  // named internal events
  logic scrub_idle, rd_fire, wr_fire, chk_single, chk_double, adv_step;

  assign scrub_idle = (state == S_IDLE);
  assign rd_fire    = (state == S_RD) && !host_busy;
  assign wr_fire    = (state == S_WR) && !host_busy;
  assign chk_single = (state == S_CHK) && (verdict == V_SINGLE);
  assign chk_double = (state == S_CHK) && (verdict == V_DOUBLE);
  assign adv_step   = wr_fire || ((state == S_CHK) && (verdict != V_SINGLE));

  scrub_pacer #(.IW(IW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(scrub_en), .idle(scrub_idle),
    .interval(scrub_interval), .kick(kick)
  );

  scrub_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .step(adv_step), .addr(addr)
  );

  secded_check u_check (
    .cw(rd_q), .verdict(verdict), .pos(bad_pos), .fixed(fixed_cw)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (kick)       state_nx = S_RD;
      S_RD:   if (rd_fire)    state_nx = S_WAIT;
      S_WAIT: if (mem_rvalid) state_nx = S_CHK;
      S_CHK:  state_nx = chk_single ? S_WR : S_IDLE;
      S_WR:   if (wr_fire)    state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rd_q     <= '0;
      wr_q     <= '0;
      ce_pulse <= 1'b0;
      ue_pulse <= 1'b0;
      ce_addr  <= '0;
      ce_pos   <= '0;
      ue_addr  <= '0;
    end else begin
      state    <= state_nx;
      ce_pulse <= chk_single;
      ue_pulse <= chk_double;
      if (state == S_WAIT && mem_rvalid) rd_q <= mem_rdata;
      if (chk_single) begin
        wr_q    <= fixed_cw;
        ce_addr <= addr;
        ce_pos  <= bad_pos;
      end
      if (chk_double) ue_addr <= addr;
    end
  end

  assign mem_req   = rd_fire || wr_fire;
  assign mem_we    = (state == S_WR);
  assign mem_addr  = addr;
  assign mem_wdata = wr_q;
endmodule

// File: rtl/scrub_chk.sv
module scrub_chk
  import scrub_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IW    = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scrub_en,
  input logic [IW-1:0] scrub_interval,
  input logic          host_busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] mem_wdata,
  input logic          ce_pulse,
  input logic [AW-1:0] ce_addr,
  input logic [PW-1:0] ce_pos,
  input logic          ue_pulse,
  input logic          scrub_idle,
  input logic          adv_step
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R7
  host_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |-> !mem_req);

  // R4
  wr_codeword_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (hamming_syndrome(mem_wdata) == '0 && (^mem_wdata) == 1'b0));

  // R8
  wr_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == ce_addr));

  // R6
  ue_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_pulse |-> !(mem_req && mem_we));

  // R5
  ce_pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse |-> (int'(ce_pos) < CW));

  // R2
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_idle && (scrub_interval == '0 || !scrub_en)) |=> scrub_idle);

  // R3
  addr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_step |=> (mem_addr == (($past(mem_addr) == LAST) ? '0 : $past(mem_addr) + AW'(1))));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_step |=> $stable(mem_addr));
endmodule

bind ecc_patrol_scrubber scrub_chk #(.DEPTH(DEPTH), .IW(IW)) i_scrub_chk (
  .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .scrub_interval(scrub_interval),
  .host_busy(host_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ce_pulse(ce_pulse), .ce_addr(ce_addr), .ce_pos(ce_pos),
  .ue_pulse(ue_pulse), .scrub_idle(scrub_idle), .adv_step(adv_step)
);

// File: tb/test_ecc_patrol_scrubber.sv
`timescale 1ns/1ps
module test_ecc_patrol_scrubber;
  localparam int DEPTH = 16;
  localparam int IW    = 8;
  localparam int AW    = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          scrub_en = 0;
  logic [IW-1:0] scrub_interval = '0;
  logic          host_busy = 0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [71:0]   mem_wdata;
  logic          mem_rvalid = 0;
  logic [71:0]   mem_rdata = '0;
  logic          ce_pulse, ue_pulse;
  logic [AW-1:0] ce_addr, ue_addr;
  logic [6:0]    ce_pos;

  always #2.5 clk = ~clk;

  ecc_patrol_scrubber #(.DEPTH(DEPTH), .IW(IW)) i_ecc_patrol_scrubber (.*);

  // memory model and monitors
  logic [71:0] mem [DEPTH];
  bit rand_busy = 0;
  bit rd_pend = 0;
  logic [AW-1:0] rd_addr_q;
  int cyc = 0, last_rd = 0;
  int n_rd = 0, n_wr = 0, n_ce = 0, n_ue = 0;
  int busy_viol = 0, gap_viol = 0;
  int rd_log [64];
  int wr_log [64];
  int ce_alog [64];
  int ce_plog [64];
  int ue_alog [64];
  int n_chk = 0, n_bad = 0;

  always @(negedge clk) begin
    if (rand_busy) host_busy = (($urandom % 10) < 3);
    #1;
    mem_rvalid = rd_pend;
    mem_rdata  = rd_pend ? mem[rd_addr_q] : '0;
    rd_pend    = 0;
    if (mem_req && host_busy) busy_viol++;
    if (mem_req && !mem_we) begin
      if (n_rd > 0 && (cyc - last_rd) < int'(scrub_interval)) gap_viol++;
      rd_log[n_rd % 64] = int'(mem_addr);
      n_rd++;
      last_rd = cyc;
      rd_pend = 1;
      rd_addr_q = mem_addr;
    end
    if (mem_req && mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_log[n_wr % 64] = int'(mem_addr);
      n_wr++;
    end
    if (ce_pulse) begin
      ce_alog[n_ce % 64] = int'(ce_addr);
      ce_plog[n_ce % 64] = int'(ce_pos);
      n_ce++;
    end
    if (ue_pulse) begin
      ue_alog[n_ue % 64] = int'(ue_addr);
      n_ue++;
    end
    cyc++;
  end

  // reference encoder: data fills non-power-of-two positions, parity per bit group
  function automatic logic [71:0] enc_ref(logic [63:0] d);
    logic [71:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 3; p < 72; p++)
      if ($countones(p) != 1) begin
        w[p] = d[j];
        j++;
      end
    for (int b = 0; b < 7; b++) begin
      logic par;
      par = 0;
      for (int p = 1; p < 72; p++)
        if (((p >> b) & 1) == 1 && p != (1 << b)) par ^= w[p];
      w[1 << b] = par;
    end
    w[0] = 0;
    for (int p = 1; p < 72; p++) w[0] ^= w[p];
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_rd = 0; n_wr = 0; n_ce = 0; n_ue = 0; busy_viol = 0; gap_viol = 0;
  endtask

  task automatic wait_reads(input int n);
    while (n_rd < n) @(negedge clk);
    rand_busy = 0;
    host_busy = 0;
    scrub_en  = 0;
    repeat (20) @(negedge clk);
  endtask

  logic [63:0] dat [DEPTH];
  int exp_pos [DEPTH];
  bit finished = 0;

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5c4b));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_req == 0 && ce_pulse == 0 && ue_pulse == 0, "R1 reset outputs", {mem_req, ce_pulse, ue_pulse}, 0);
    rst_n = 1;
    @(negedge clk);
    #2;
    chk(mem_req == 0 && ce_pulse == 0 && ue_pulse == 0, "R1 after reset", {mem_req, ce_pulse, ue_pulse}, 0);

    // directed pass
    for (int a = 0; a < DEPTH; a++) begin
      dat[a] = {$urandom, $urandom};
      mem[a] = enc_ref(dat[a]);
    end
    mem[3]  ^= 72'(1) << 37;
    mem[5]  ^= 72'(1) << 8;
    mem[7]  ^= 72'(1);
    mem[9]  ^= (72'(1) << 10) | (72'(1) << 50);
    mem[12] ^= 72'(1) << 71;
    begin
      logic [71:0] bad9;
      bad9 = mem[9];
      clear_logs();
      scrub_interval = 4;
      rand_busy = 1;
      scrub_en = 1;
      wait_reads(DEPTH);
      for (int i = 0; i < DEPTH; i++)
        chk(rd_log[i] == i, "R3 read order", 72'(rd_log[i]), 72'(i));
      chk(mem[3] == enc_ref(dat[3]), "R4 data bit fixed", mem[3], enc_ref(dat[3]));
      chk(mem[12] == enc_ref(dat[12]), "R4 top data bit fixed", mem[12], enc_ref(dat[12]));
      chk(mem[5] == enc_ref(dat[5]), "R9 check bit fixed", mem[5], enc_ref(dat[5]));
      chk(mem[7] == enc_ref(dat[7]), "R9 parity bit fixed", mem[7], enc_ref(dat[7]));
      chk(n_ce == 4, "R5 ce count", 72'(n_ce), 4);
      chk(ce_alog[0] == 3 && ce_plog[0] == 37, "R5 ce 0", 72'({ce_alog[0], ce_plog[0]}), 72'({32'd3, 32'd37}));
      chk(ce_alog[1] == 5 && ce_plog[1] == 8, "R5 ce 1", 72'({ce_alog[1], ce_plog[1]}), 72'({32'd5, 32'd8}));
      chk(ce_alog[2] == 7 && ce_plog[2] == 0, "R5 ce 2", 72'({ce_alog[2], ce_plog[2]}), 72'({32'd7, 32'd0}));
      chk(ce_alog[3] == 12 && ce_plog[3] == 71, "R5 ce 3", 72'({ce_alog[3], ce_plog[3]}), 72'({32'd12, 32'd71}));
      chk(n_ue == 1 && ue_alog[0] == 9, "R6 ue event", 72'({n_ue, ue_alog[0]}), 72'({32'd1, 32'd9}));
      chk(mem[9] == bad9, "R6 ue word untouched", mem[9], bad9);
      chk(n_wr == 4, "R8 only corrected words written", 72'(n_wr), 4);
      chk(wr_log[0] == 3 && wr_log[1] == 5 && wr_log[2] == 7 && wr_log[3] == 12,
          "R8 write addresses", 72'({wr_log[0], wr_log[1]}), 72'({32'd3, 32'd5}));
      chk(busy_viol == 0, "R7 no request under host_busy", 72'(busy_viol), 0);
      chk(gap_viol == 0, "R11 read spacing", 72'(gap_viol), 0);
    end

    // random pass, starting with a long host hold
    for (int a = 0; a < DEPTH; a++) begin
      dat[a] = {$urandom, $urandom};
      mem[a] = enc_ref(dat[a]);
      exp_pos[a] = -1;
      if (($urandom % 3) == 0) begin
        exp_pos[a] = int'($urandom % 72);
        mem[a] ^= 72'(1) << exp_pos[a];
      end
    end
    clear_logs();
    scrub_interval = 2;
    host_busy = 1;
    scrub_en = 1;
    repeat (50) @(negedge clk);
    chk(n_rd == 0, "R7 held off by host", 72'(n_rd), 0);
    host_busy = 0;
    while (n_rd < 1) @(negedge clk);
    chk(rd_log[0] == 0, "R3 R7 wrap and no skip", 72'(rd_log[0]), 0);
    scrub_interval = 7;
    rand_busy = 1;
    wait_reads(DEPTH);
    begin
      int n_exp;
      bit all_ok;
      n_exp = 0;
      all_ok = 1;
      for (int a = 0; a < DEPTH; a++) begin
        if (exp_pos[a] >= 0) n_exp++;
        if (mem[a] != enc_ref(dat[a])) all_ok = 0;
      end
      chk(all_ok, "R4 random words repaired", 72'(all_ok), 1);
      chk(n_ce == n_exp, "R5 random ce count", 72'(n_ce), 72'(n_exp));
      all_ok = 1;
      for (int i = 0; i < n_ce && i < 64; i++)
        if (exp_pos[ce_alog[i]] != ce_plog[i]) all_ok = 0;
      chk(all_ok, "R5 random ce positions", 72'(all_ok), 1);
      chk(n_wr == n_exp, "R8 random write count", 72'(n_wr), 72'(n_exp));
      chk(busy_viol == 0, "R7 random host_busy", 72'(busy_viol), 0);
      chk(gap_viol == 0, "R11 random spacing", 72'(gap_viol), 0);
    end

    // pause with interval 0
    scrub_interval = 0;
    clear_logs();
    scrub_en = 1;
    repeat (100) @(negedge clk);
    chk(n_rd == 0, "R2 interval zero pauses", 72'(n_rd), 0);
    // disable
    scrub_en = 0;
    scrub_interval = 3;
    repeat (100) @(negedge clk);
    chk(n_rd == 0, "R10 enable low idles", 72'(n_rd), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule